// File: doc/BRIEF.md
# Lazy Read-Set Validation Commit Sequencer

This block controls the end of a hardware transaction when conflict detection is deferred until commit. While the transaction runs, the cache keeps lines that were read and later invalidated in a stale-but-present form. It lets loads use those lines on a predicted value and logs each predicted word. Stores sit in a store buffer. When the core asks to commit, the sequencer takes a lock so that the cache refuses further invalidations. It then fetches every stale line again with read-shared permission and checks each logged prediction for that line against the fresh data.

If the read set holds, the sequencer upgrades every store-buffer line that is not already Exclusive with a read-exclusive request. It then writes the buffered stores into the cache one per cycle and reports a commit. A NACK on any request, or a failed prediction, ends the attempt with an abort. An abort clears the store buffer and the validation log and drops the lock. A NACK that the core receives while the transaction is still executing also aborts it.

The cache must hold the stale list, the log and the store buffer steady from the commit request until the commit or abort pulse. The coherence port allows one request in flight: a single-cycle request pulse, then a single-cycle response carrying ACK, NACK or line data.

Top module: `tcv_commit_seq`

## Requirements
- R1: A commit request sampled while idle raises `lock` on the next cycle. `lock` stays high until the cycle of the commit or abort pulse, and no coherence request is issued while `lock` is low.
- R2: Each slot set in `stale_valid` gets one read-shared request (`req_excl`=0, `req_addr` = that slot's address), in ascending slot order. A request is one cycle wide, and no new request appears until the previous one has been answered.
- R3: On a data reply for stale slot s, every valid log entry whose slot field equals s is compared with word `resp_data[off*DATA_W +: DATA_W]`, where off is the entry's word-offset field. Any inequality aborts. Entries for other slots are not checked against this line.
- R4: A NACK reply to a read-shared or read-exclusive request aborts, and no further request is issued.
- R5: After all stale slots validate, each store-buffer entry that is valid with `sb_excl`=0 gets one read-exclusive request (`req_excl`=1, its address), in ascending index order. Entries with `sb_excl`=1 get none.
- R6: `exec_nack` asserted while idle produces an abort pulse on the next cycle.
- R7: After write-permission acquisition, each valid store-buffer entry is written once, in ascending index order, one per cycle, with its address, word offset and data on `wr_*`. No write happens on an abort.
- R8: An abort is a one-cycle `abort` pulse with `sb_clear` and `log_clear` high in the same cycle and `lock` low.
- R9: A commit is a one-cycle `commit_done` pulse with `sb_clear` and `log_clear` high in the same cycle and `lock` low. `commit_done` and `abort` never coincide.
- R10: With no stale slots and an empty store buffer, `commit_done` is high in the fifth cycle after the commit request is sampled, and no coherence request is issued.
- R11: After reset, `lock`, `req_valid`, `wr_en`, `commit_done` and `abort` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit_req | input | 1 | Start pre-commit (sampled while idle) |
| exec_nack | input | 1 | NACK seen during transactional execution |
| stale_valid | input | N_STALE | Stale-line slot occupied |
| stale_addr | input | N_STALE*ADDR_W | Line address per stale slot |
| log_valid | input | N_LOG | Validation log entry valid |
| log_slot | input | N_LOG*SLOT_W | Stale slot each log entry belongs to |
| log_off | input | N_LOG*OFF_W | Word offset of each predicted value |
| log_pred | input | N_LOG*DATA_W | Predicted word value |
| sb_valid | input | N_SB | Store-buffer entry valid |
| sb_excl | input | N_SB | Entry's line already Exclusive in the L1 |
| sb_addr | input | N_SB*ADDR_W | Store line address |
| sb_off | input | N_SB*OFF_W | Store word offset |
| sb_data | input | N_SB*DATA_W | Store data |
| req_valid | output | 1 | Coherence request pulse |
| req_excl | output | 1 | 1 = read-exclusive, 0 = read-shared |
| req_addr | output | ADDR_W | Requested line address |
| resp_valid | input | 1 | Coherence reply |
| resp_nack | input | 1 | Reply is a NACK |
| resp_data | input | WORDS*DATA_W | Line data for read-shared replies |
| lock | output | 1 | Read/write set locked; cache NACKs invalidations |
| wr_en | output | 1 | Apply one buffered store |
| wr_addr | output | ADDR_W | Store line address |
| wr_off | output | OFF_W | Store word offset |
| wr_data | output | DATA_W | Store data |
| sb_clear | output | 1 | Empty the store buffer |
| log_clear | output | 1 | Empty the validation log |
| commit_done | output | 1 | Transaction committed |
| abort | output | 1 | Transaction aborted |

## Verification
Some rules are checked by assertions on every cycle. A request always falls under the lock and is never longer than one cycle. A NACK in either validation phase, or during execution, is followed by an abort. Writes happen only under the lock with no request pending, and the end pulses always carry both clears with the lock released. Only the bench's scenarios can show the rest. That covers the order of the requests and where the sequence stops after a misprediction or a NACK. It also covers skipping lines that are already Exclusive, the order and contents of the drained stores, the fact that log entries for other slots are left alone, and the exact latency of an empty commit.

// File: rtl/tcv_pkg.sv
package tcv_pkg;

    localparam int TCV_ADDR_W = 8;
    localparam int TCV_DATA_W = 8;
    localparam int TCV_WORDS  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOCK,
        ST_RS_NEXT,
        ST_RS_REQ,
        ST_RS_WAIT,
        ST_WS_NEXT,
        ST_WS_REQ,
        ST_WS_WAIT,
        ST_DRAIN,
        ST_DONE,
        ST_ABORT
    } seq_state_e;

    // Index width for n entries, never below one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tcv_pick_first.sv
// Lowest set bit of mask at or above a start index.
module tcv_pick_first #(
    parameter int N    = 4,
    parameter int IW   = 3,
    parameter int SELW = 2
) (
    input  logic [N-1:0]    mask,
    input  logic [IW-1:0]   start,
    output logic            found,
    output logic [SELW-1:0] sel
);
    logic [N-1:0] qual;

    for (genvar g = 0; g < N; g++) begin : g_qual
        assign qual[g] = mask[g] && (start <= IW'(g));
    end

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (qual[i]) begin
                found = 1'b1;
                sel   = SELW'(i);
            end
        end
    end
endmodule

// File: rtl/tcv_log_check.sv
// Compares every logged prediction for one stale slot with a fresh line.
module tcv_log_check #(
    parameter int N_LOG  = 4,
    parameter int SLOT_W = 2,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 8,
    parameter int WORDS  = 4
) (
    input  logic [N_LOG-1:0]        log_valid,
    input  logic [N_LOG*SLOT_W-1:0] log_slot,
    input  logic [N_LOG*OFF_W-1:0]  log_off,
    input  logic [N_LOG*DATA_W-1:0] log_pred,
    input  logic [SLOT_W-1:0]       cur_slot,
    input  logic [WORDS*DATA_W-1:0] line,
    output logic                    mismatch
);
    logic [DATA_W-1:0] word_a [WORDS];
    logic [N_LOG-1:0]  bad;

    for (genvar k = 0; k < WORDS; k++) begin : g_word
        assign word_a[k] = line[k*DATA_W +: DATA_W];
    end

    for (genvar e = 0; e < N_LOG; e++) begin : g_entry
        logic [OFF_W-1:0] off;
        assign off    = log_off[e*OFF_W +: OFF_W];
        assign bad[e] = log_valid[e]
                     && (log_slot[e*SLOT_W +: SLOT_W] == cur_slot)
                     && (word_a[off] != log_pred[e*DATA_W +: DATA_W]);
    end

    assign mismatch = |bad;
endmodule

// File: rtl/tcv_commit_seq.sv
module tcv_commit_seq
    import tcv_pkg::*;
#(
    parameter int N_STALE = 4,
    parameter int N_LOG   = 4,
    parameter int N_SB    = 4,
    parameter int ADDR_W  = TCV_ADDR_W,
    parameter int DATA_W  = TCV_DATA_W,
    parameter int WORDS   = TCV_WORDS,
    parameter int SLOT_W  = idx_w(N_STALE),
    parameter int OFF_W   = idx_w(WORDS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      commit_req,
    input  logic                      exec_nack,
    input  logic [N_STALE-1:0]        stale_valid,
    input  logic [N_STALE*ADDR_W-1:0] stale_addr,
    input  logic [N_LOG-1:0]          log_valid,
    input  logic [N_LOG*SLOT_W-1:0]   log_slot,
    input  logic [N_LOG*OFF_W-1:0]    log_off,
    input  logic [N_LOG*DATA_W-1:0]   log_pred,
    input  logic [N_SB-1:0]           sb_valid,
    input  logic [N_SB-1:0]           sb_excl,
    input  logic [N_SB*ADDR_W-1:0]    sb_addr,
    input  logic [N_SB*OFF_W-1:0]     sb_off,
    input  logic [N_SB*DATA_W-1:0]    sb_data,
    output logic                      req_valid,
    output logic                      req_excl,
    output logic [ADDR_W-1:0]         req_addr,
    input  logic                      resp_valid,
    input  logic                      resp_nack,
    input  logic [WORDS*DATA_W-1:0]   resp_data,
    output logic                      lock,
    output logic                      wr_en,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [OFF_W-1:0]          wr_off,
    output logic [DATA_W-1:0]         wr_data,
    output logic                      sb_clear,
    output logic                      log_clear,
    output logic                      commit_done,
    output logic                      abort
);
    localparam int RIW  = $clog2(N_STALE + 1);
    localparam int BIW  = $clog2(N_SB + 1);
    localparam int BSEL = idx_w(N_SB);

    seq_state_e        state_q;
    logic [RIW-1:0]    rs_idx_q;
    logic [BIW-1:0]    sb_idx_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic              req_excl_q;

    logic [ADDR_W-1:0] stale_addr_a [N_STALE];
    logic [ADDR_W-1:0] sb_addr_a    [N_SB];
    logic [OFF_W-1:0]  sb_off_a     [N_SB];
    logic [DATA_W-1:0] sb_data_a    [N_SB];

    for (genvar s = 0; s < N_STALE; s++) begin : g_stale
        assign stale_addr_a[s] = stale_addr[s*ADDR_W +: ADDR_W];
    end
    for (genvar b = 0; b < N_SB; b++) begin : g_sb
        assign sb_addr_a[b] = sb_addr[b*ADDR_W +: ADDR_W];
        assign sb_off_a[b]  = sb_off[b*OFF_W +: OFF_W];
        assign sb_data_a[b] = sb_data[b*DATA_W +: DATA_W];
    end

    // Next stale slot to revalidate
    logic              rs_found;
    logic [SLOT_W-1:0] rs_sel;
    tcv_pick_first #(.N(N_STALE), .IW(RIW), .SELW(SLOT_W)) u_rs_pick (
        .mask (stale_valid),
        .start(rs_idx_q),
        .found(rs_found),
        .sel  (rs_sel)
    );

    // Next store-buffer entry: non-exclusive lines while upgrading, all while draining
    logic [N_SB-1:0]   sb_mask;
    logic              sb_found;
    logic [BSEL-1:0]   sb_sel;
    assign sb_mask = (state_q == ST_DRAIN) ? sb_valid : (sb_valid & ~sb_excl);
    tcv_pick_first #(.N(N_SB), .IW(BIW), .SELW(BSEL)) u_sb_pick (
        .mask (sb_mask),
        .start(sb_idx_q),
        .found(sb_found),
        .sel  (sb_sel)
    );

    logic log_bad;
    tcv_log_check #(
        .N_LOG(N_LOG), .SLOT_W(SLOT_W), .OFF_W(OFF_W),
        .DATA_W(DATA_W), .WORDS(WORDS)
    ) u_check (
        .log_valid(log_valid),
        .log_slot (log_slot),
        .log_off  (log_off),
        .log_pred (log_pred),
        .cur_slot (rs_idx_q[SLOT_W-1:0]),
        .line     (resp_data),
        .mismatch (log_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            rs_idx_q   <= '0;
            sb_idx_q   <= '0;
            req_addr_q <= '0;
            req_excl_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (exec_nack)       state_q <= ST_ABORT;
                    else if (commit_req) state_q <= ST_LOCK;
                end
                ST_LOCK: begin
                    rs_idx_q <= '0;
                    state_q  <= ST_RS_NEXT;
                end
                ST_RS_NEXT: begin
                    if (rs_found) begin
                        rs_idx_q   <= RIW'(rs_sel);
                        req_addr_q <= stale_addr_a[rs_sel];
                        req_excl_q <= 1'b0;
                        state_q    <= ST_RS_REQ;
                    end else begin
                        sb_idx_q <= '0;
                        state_q  <= ST_WS_NEXT;
                    end
                end
                ST_RS_REQ: state_q <= ST_RS_WAIT;
                ST_RS_WAIT: begin
                    if (resp_valid) begin
                        if (resp_nack || log_bad) begin
                            state_q <= ST_ABORT;
                        end else begin
                            rs_idx_q <= rs_idx_q + RIW'(1);
                            state_q  <= ST_RS_NEXT;
                        end
                    end
                end
                ST_WS_NEXT: begin
                    if (sb_found) begin
                        sb_idx_q   <= BIW'(sb_sel);
                        req_addr_q <= sb_addr_a[sb_sel];
                        req_excl_q <= 1'b1;
                        state_q    <= ST_WS_REQ;
                    end else begin
                        sb_idx_q <= '0;
                        state_q  <= ST_DRAIN;
                    end
                end
                ST_WS_REQ: state_q <= ST_WS_WAIT;
                ST_WS_WAIT: begin
                    if (resp_valid) begin
                        if (resp_nack) begin
                            state_q <= ST_ABORT;
                        end else begin
                            sb_idx_q <= sb_idx_q + BIW'(1);
                            state_q  <= ST_WS_NEXT;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (sb_found) sb_idx_q <= BIW'(sb_sel) + BIW'(1);
                    else          state_q  <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign lock        = state_q inside {ST_LOCK, ST_RS_NEXT, ST_RS_REQ, ST_RS_WAIT,
                                         ST_WS_NEXT, ST_WS_REQ, ST_WS_WAIT, ST_DRAIN};
    assign req_valid   = (state_q == ST_RS_REQ) || (state_q == ST_WS_REQ);
    assign req_excl    = req_excl_q;
    assign req_addr    = req_addr_q;
    assign wr_en       = (state_q == ST_DRAIN) && sb_found;
    assign wr_addr     = sb_addr_a[sb_sel];
    assign wr_off      = sb_off_a[sb_sel];
    assign wr_data     = sb_data_a[sb_sel];
    assign commit_done = (state_q == ST_DONE);
    assign abort       = (state_q == ST_ABORT);
    assign sb_clear    = commit_done || abort;
    assign log_clear   = commit_done || abort;

    AST_REQ_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> lock); // R1
    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid); // R2
    AST_NACK_ABORTS: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_RS_WAIT || state_q == ST_WS_WAIT) && resp_valid && resp_nack)
        |=> abort); // R4
    AST_EXEC_NACK: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && exec_nack) |=> abort); // R6
    AST_WR_LOCKED: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (lock && !req_valid)); // R7
    AST_END_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (abort || commit_done) |-> (sb_clear && log_clear && !lock)); // R8
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(abort && commit_done)); // R9
endmodule

// File: tb/tb_tcv_commit_seq.sv
`timescale 1ns/1ps
module tb_tcv_commit_seq;
    localparam int NS = 4, NL = 4, NB = 4, AW = 8, DW = 8, WPL = 4, SW = 2, OW = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, commit_req, exec_nack;
    logic [NS-1:0] stale_valid;
    logic [NS*AW-1:0] stale_addr;
    logic [NL-1:0] log_valid;
    logic [NL*SW-1:0] log_slot;
    logic [NL*OW-1:0] log_off;
    logic [NL*DW-1:0] log_pred;
    logic [NB-1:0] sb_valid, sb_excl;
    logic [NB*AW-1:0] sb_addr;
    logic [NB*OW-1:0] sb_off;
    logic [NB*DW-1:0] sb_data;
    logic req_valid, req_excl;
    logic [AW-1:0] req_addr;
    logic resp_valid, resp_nack;
    logic [WPL*DW-1:0] resp_data;
    logic lock, wr_en, sb_clear, log_clear, commit_done, abort;
    logic [AW-1:0] wr_addr;
    logic [OW-1:0] wr_off;
    logic [DW-1:0] wr_data;

    tcv_commit_seq dut (
        .clk(clk), .rst(rst), .commit_req(commit_req), .exec_nack(exec_nack),
        .stale_valid(stale_valid), .stale_addr(stale_addr),
        .log_valid(log_valid), .log_slot(log_slot), .log_off(log_off), .log_pred(log_pred),
        .sb_valid(sb_valid), .sb_excl(sb_excl), .sb_addr(sb_addr), .sb_off(sb_off),
        .sb_data(sb_data), .req_valid(req_valid), .req_excl(req_excl), .req_addr(req_addr),
        .resp_valid(resp_valid), .resp_nack(resp_nack), .resp_data(resp_data),
        .lock(lock), .wr_en(wr_en), .wr_addr(wr_addr), .wr_off(wr_off), .wr_data(wr_data),
        .sb_clear(sb_clear), .log_clear(log_clear), .commit_done(commit_done), .abort(abort)
    );

    int tests = 0, fails = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    typedef struct packed {
        logic [3:0] stale, sbv, sbx, bad;
        logic [2:0] nack_n;
        logic       exp_commit;
        logic [3:0] exp_reqs, exp_wr;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{4'b0000, 4'b0000, 4'b0000, 4'b0000, 3'd0, 1'b1, 4'd0, 4'd0},
        '{4'b0101, 4'b0011, 4'b0001, 4'b0000, 3'd0, 1'b1, 4'd3, 4'd2},
        '{4'b1111, 4'b1111, 4'b0000, 4'b0100, 3'd0, 1'b0, 4'd3, 4'd0},
        '{4'b0011, 4'b0110, 4'b0000, 4'b0000, 3'd3, 1'b0, 4'd3, 4'd0},
        '{4'b0010, 4'b0001, 4'b0000, 4'b0000, 3'd1, 1'b0, 4'd1, 4'd0},
        '{4'b0000, 4'b1111, 4'b1111, 4'b0000, 3'd0, 1'b1, 4'd0, 4'd4},
        '{4'b1000, 4'b1001, 4'b0000, 4'b0000, 3'd0, 1'b1, 4'd3, 4'd2}
    };

    function automatic logic [7:0] linew(input logic [7:0] a, input int k);
        return a ^ 8'(k * 17) ^ 8'h5A;
    endfunction
    function automatic logic [7:0] s_addr(input int i); return 8'(16 + i * 3); endfunction
    function automatic logic [7:0] b_addr(input int i); return 8'(64 + i); endfunction
    function automatic logic [7:0] b_data(input int i); return 8'(160 + i); endfunction

    task automatic load(input vec_t v);
        stale_valid = v.stale; log_valid = v.stale;
        sb_valid = v.sbv; sb_excl = v.sbx;
        for (int i = 0; i < 4; i++) begin
            stale_addr[i*AW +: AW] = s_addr(i);
            log_slot[i*SW +: SW]   = 2'(i);
            log_off[i*OW +: OW]    = 2'((i + 1) % 4);
            log_pred[i*DW +: DW]   = linew(s_addr(i), (i + 1) % 4) ^ (v.bad[i] ? 8'hFF : 8'h00);
            sb_addr[i*AW +: AW]    = b_addr(i);
            sb_off[i*OW +: OW]     = 2'(3 - i);
            sb_data[i*DW +: DW]    = b_data(i);
        end
    endtask

    logic [7:0] rq_addr [16];
    logic       rq_excl [16];
    logic [7:0] w_addr [16];
    logic [1:0] w_off  [16];
    logic [7:0] w_data [16];
    int n_rq, n_wr, overlap;
    bit got_commit, got_abort, end_clear, end_lock, ended;

    // Drives commit_req, answers requests two cycles late, records everything.
    task automatic run(input logic [2:0] nack_n);
        int pend = 0;
        logic [7:0] cur = '0;
        n_rq = 0; n_wr = 0; overlap = 0;
        got_commit = 0; got_abort = 0; ended = 0; end_clear = 0; end_lock = 1;
        @(negedge clk); commit_req = 1'b1;
        @(negedge clk); commit_req = 1'b0;
        for (int c = 0; c < 300 && !ended; c++) begin
            if (resp_valid) resp_valid = 1'b0;
            if (req_valid) begin
                if (pend > 0) overlap++;
                if (n_rq < 16) begin rq_addr[n_rq] = req_addr; rq_excl[n_rq] = req_excl; end
                n_rq++; cur = req_addr; pend = 2;
            end else if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    resp_valid = 1'b1;
                    resp_nack  = (n_rq == int'(nack_n));
                    for (int k = 0; k < 4; k++) resp_data[k*DW +: DW] = linew(cur, k);
                end
            end
            if (wr_en && n_wr < 16) begin
                w_addr[n_wr] = wr_addr; w_off[n_wr] = wr_off; w_data[n_wr] = wr_data; n_wr++;
            end
            if (commit_done || abort) begin
                got_commit = commit_done; got_abort = abort; ended = 1;
                end_clear = sb_clear && log_clear; end_lock = lock;
            end
            @(negedge clk);
        end
        resp_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; commit_req = 0; exec_nack = 0; resp_valid = 0; resp_nack = 0; resp_data = '0;
        load(VECS[0]);
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!lock && !req_valid && !wr_en && !commit_done && !abort, "R11 reset outputs",
              {lock, req_valid, wr_en, commit_done, abort}, 0);
        rst = 1'b0;
        @(negedge clk);

        foreach (VECS[vi]) begin
            vec_t v = VECS[vi];
            int e_n = 0; bit stop = 0;
            logic [7:0] e_a [16]; logic e_x [16];
            load(v);
            for (int i = 0; i < 4 && !stop; i++) if (v.stale[i]) begin
                e_a[e_n] = s_addr(i); e_x[e_n] = 0; e_n++;
                if (v.bad[i] || e_n == int'(v.nack_n)) stop = 1;
            end
            for (int i = 0; i < 4 && !stop; i++) if (v.sbv[i] && !v.sbx[i]) begin
                e_a[e_n] = b_addr(i); e_x[e_n] = 1; e_n++;
                if (e_n == int'(v.nack_n)) stop = 1;
            end
            run(v.nack_n);
            check(ended && got_commit == v.exp_commit && got_abort == !v.exp_commit,
                  "R8 R9 outcome", {got_commit, got_abort}, {v.exp_commit, !v.exp_commit});
            check(end_clear && !end_lock, "R8 R9 clears and unlock", {end_clear, end_lock}, 2);
            check(n_rq == int'(v.exp_reqs) && n_rq == e_n, "R2 R4 R5 request count",
                  n_rq, v.exp_reqs);
            check(overlap == 0, "R2 one outstanding", overlap, 0);
            for (int i = 0; i < e_n && i < n_rq; i++)
                check(rq_addr[i] == e_a[i] && rq_excl[i] == e_x[i], "R2 R3 R5 request order",
                      {rq_excl[i], rq_addr[i]}, {e_x[i], e_a[i]});
            check(n_wr == int'(v.exp_wr), "R7 write count", n_wr, v.exp_wr);
            begin
                int k = 0;
                for (int i = 0; i < 4; i++) if (v.exp_commit && v.sbv[i] && k < n_wr) begin
                    check(w_addr[k] == b_addr(i) && w_off[k] == 2'(3 - i) && w_data[k] == b_data(i),
                          "R7 drain contents", {w_addr[k], w_off[k], w_data[k]},
                          {b_addr(i), 2'(3 - i), b_data(i)});
                    k++;
                end
            end
            @(negedge clk);
        end

        // R10 empty transaction latency; R1 lock one cycle after request
        load(VECS[0]);
        @(negedge clk); commit_req = 1'b1;
        begin
            int seen = 0, reqs = 0;
            for (int i = 1; i <= 8; i++) begin
                @(negedge clk);
                commit_req = 1'b0;
                if (i == 1) check(lock, "R1 lock after commit_req", lock, 1);
                if (req_valid) reqs++;
                if (commit_done && seen == 0) seen = i;
            end
            check(seen == 5, "R10 empty commit latency", seen, 5);
            check(reqs == 0, "R10 no requests", reqs, 0);
        end

        // R6 exec-phase NACK
        @(negedge clk); exec_nack = 1'b1;
        @(negedge clk); exec_nack = 1'b0;
        check(abort && sb_clear && log_clear && !lock, "R6 exec nack aborts",
              {abort, sb_clear, log_clear, lock}, 4'b1110);
        @(negedge clk);
        check(!abort && !lock, "R6 abort single cycle", {abort, lock}, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule